// File: doc/BRIEF.md
# Pixel Layer Priority and Colour Mixer

This block takes the two layer results for one pixel and turns them into a final colour. The inputs are the background result (a 4-bit colour index, a palette-half bit and a priority bit) and the sprite result (a 4-bit colour index). The block picks which layer is visible and looks up the winning index in a small colour table of 6-bit entries. It then applies left-edge blanking and the global display switch. Besides the colour, it produces the frame-store write address for the pixel.

A pixel is presented with `pix_valid` together with its column and line. Exactly one cycle later, `px_we` pulses for one cycle with the colour and address. The colour table is loaded through a separate write port, one entry per cycle. A pixel lookup does not stall while that port is in use.

Top module: `pix_mix_top`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `px_we`, `px_color` and `px_addr` are 0. All 32 colour-table entries are cleared to 0.
- R2: When `bg_idx` is nonzero and either `bg_pri` is 1 or `spr_idx` is 0, the colour is table entry `bg_pal*16 + bg_idx`.
- R3: When the background does not win and `spr_idx` is nonzero, the colour is table entry `16 + spr_idx`.
- R4: When both `bg_idx` and `spr_idx` are 0, the colour is table entry `backdrop_sel`, which addresses entries 0 to 15.
- R5: When `left_clip_en` is 1 and `pix_x` is 0 to 7, the colour is table entry `backdrop_sel` whatever the layers hold. From column 8 upwards, clipping has no effect.
- R6: When `disp_en` is 0, the colour is 0. This overrides every other rule, including the clip rule.
- R7: `px_addr` equals `pix_line*256 + pix_x`, so the line sits in bits 15:8 and the column in bits 7:0.
- R8: A pixel sampled with `pix_valid`=1 produces `px_we`=1 on the next cycle. A cycle with `pix_valid`=0 produces `px_we`=0, and `px_color` and `px_addr` hold their previous values.
- R9: With `cram_we`=1, `cram_wdata` is stored at entry `cram_waddr` at the clock edge, and no other entry changes. A lookup of that same entry in the same cycle returns the old contents. Lookups from the next cycle on return the new value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_valid | input | 1 | A pixel is presented this cycle |
| pix_x | input | 8 | Pixel column |
| pix_line | input | 8 | Pixel line |
| bg_idx | input | 4 | Background colour index, 0 = transparent |
| bg_pal | input | 1 | Background palette half select |
| bg_pri | input | 1 | Background drawn above sprites |
| spr_idx | input | 4 | Sprite colour index, 0 = transparent |
| backdrop_sel | input | 4 | Table entry used for backdrop and clipped columns |
| left_clip_en | input | 1 | Blank the first 8 columns to the backdrop |
| disp_en | input | 1 | Display on; when 0 the output colour is black |
| cram_we | input | 1 | Colour-table write strobe |
| cram_waddr | input | 5 | Colour-table write entry |
| cram_wdata | input | 6 | Colour-table write value |
| px_we | output | 1 | Frame-store write strobe, one cycle after `pix_valid` |
| px_color | output | 6 | Final pixel colour |
| px_addr | output | 16 | Frame-store address of the pixel |

## Verification
The stimulus combines three kinds of pixel:
- **Opaque over opaque.** Both layers are opaque and the priority bit is toggled. This separates the R2 background win from the R3 sprite win.
- **Partly transparent.** One layer or both are transparent. This shows whether a zero index is treated as see-through, and whether the backdrop entry is reached.
- **Left edge.** Pixels at columns 7 and 8 with clipping on. This locates the clip boundary, and the same pixel with the display off shows that blanking takes precedence over clipping.

Random table writes land in the same cycle as lookups of the same entry. This exposes whether a lookup sees the old or the new contents. Idle cycles check that the outputs hold their values.

// File: rtl/pix_mix_pkg.sv
package pix_mix_pkg;

    localparam int DEF_COLOR_W   = 6;
    localparam int DEF_IDX_W     = 4;
    localparam int DEF_X_W       = 8;
    localparam int DEF_LINE_W    = 8;
    localparam int DEF_CLIP_COLS = 8;

    typedef enum logic [1:0] {
        SRC_BACKDROP = 2'd0,
        SRC_BG       = 2'd1,
        SRC_SPR      = 2'd2
    } layer_src_e;

endpackage

// File: rtl/pix_layer_sel.sv
module pix_layer_sel
    import pix_mix_pkg::*;
#(
    parameter int IDX_W     = DEF_IDX_W,
    parameter int X_W       = DEF_X_W,
    parameter int CLIP_COLS = DEF_CLIP_COLS,
    localparam int AW       = IDX_W + 1
) (
    input  logic [IDX_W-1:0] bg_idx,
    input  logic             bg_pal,
    input  logic             bg_pri,
    input  logic [IDX_W-1:0] spr_idx,
    input  logic [X_W-1:0]   pix_x,
    input  logic [IDX_W-1:0] backdrop_sel,
    input  logic             left_clip_en,
    output logic [AW-1:0]    rd_addr
);

    layer_src_e src;
    logic       in_clip;
    logic       bg_opaque;
    logic       spr_opaque;

    // Decide the visible layer, then form the table entry address.
    always_comb begin
        in_clip    = left_clip_en && (pix_x < X_W'(CLIP_COLS));
        bg_opaque  = |bg_idx;
        spr_opaque = |spr_idx;
        src        = SRC_BACKDROP;
        if (!in_clip) begin
            if (bg_opaque && (bg_pri || !spr_opaque)) begin
                src = SRC_BG;
            end else if (spr_opaque) begin
                src = SRC_SPR;
            end
        end
        case (src)
            SRC_BG:  rd_addr = {bg_pal, bg_idx};
            SRC_SPR: rd_addr = {1'b1, spr_idx};
            default: rd_addr = {1'b0, backdrop_sel};
        endcase
    end

endmodule

// File: rtl/pix_cram.sv
module pix_cram #(
    parameter int COLOR_W = 6,
    parameter int DEPTH   = 32,
    localparam int AW     = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [AW-1:0]      wr_addr,
    input  logic [COLOR_W-1:0] wr_data,
    input  logic [AW-1:0]      rd_addr,
    output logic [COLOR_W-1:0] rd_data
);

    logic [COLOR_W-1:0] ent_view [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        logic [COLOR_W-1:0] ent_d;
        logic [COLOR_W-1:0] ent_q;

        always_comb begin
            ent_d = ent_q;
            if (wr_en && (wr_addr == AW'(g))) begin
                ent_d = wr_data;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_q <= '0;
            end else begin
                ent_q <= ent_d;
            end
        end

        assign ent_view[g] = ent_q;
    end

    // Read returns the stored value, i.e. the contents before any write at this edge.
    assign rd_data = ent_view[rd_addr];

endmodule

// File: rtl/pix_out_stage.sv
module pix_out_stage #(
    parameter int COLOR_W = 6,
    parameter int X_W     = 8,
    parameter int LINE_W  = 8,
    localparam int ADDR_W = LINE_W + X_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pix_valid,
    input  logic               disp_en,
    input  logic [COLOR_W-1:0] lut_data,
    input  logic [X_W-1:0]     pix_x,
    input  logic [LINE_W-1:0]  pix_line,
    output logic               px_we,
    output logic [COLOR_W-1:0] px_color,
    output logic [ADDR_W-1:0]  px_addr
);

    typedef struct packed {
        logic               we;
        logic [COLOR_W-1:0] color;
        logic [ADDR_W-1:0]  addr;
    } out_t;

    out_t st_d;
    out_t st_q;

    always_comb begin
        st_d    = st_q;
        st_d.we = 1'b0;
        if (pix_valid) begin
            st_d.we    = 1'b1;
            st_d.color = disp_en ? lut_data : '0;
            st_d.addr  = {pix_line, pix_x};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign px_we    = st_q.we;
    assign px_color = st_q.color;
    assign px_addr  = st_q.addr;

endmodule

// File: rtl/pix_mix_top.sv
module pix_mix_top
    import pix_mix_pkg::*;
#(
    parameter int COLOR_W   = DEF_COLOR_W,
    parameter int IDX_W     = DEF_IDX_W,
    parameter int X_W       = DEF_X_W,
    parameter int LINE_W    = DEF_LINE_W,
    parameter int CLIP_COLS = DEF_CLIP_COLS,
    localparam int AW       = IDX_W + 1,
    localparam int DEPTH    = 2 ** AW,
    localparam int ADDR_W   = LINE_W + X_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pix_valid,
    input  logic [X_W-1:0]     pix_x,
    input  logic [LINE_W-1:0]  pix_line,
    input  logic [IDX_W-1:0]   bg_idx,
    input  logic               bg_pal,
    input  logic               bg_pri,
    input  logic [IDX_W-1:0]   spr_idx,
    input  logic [IDX_W-1:0]   backdrop_sel,
    input  logic               left_clip_en,
    input  logic               disp_en,
    input  logic               cram_we,
    input  logic [AW-1:0]      cram_waddr,
    input  logic [COLOR_W-1:0] cram_wdata,
    output logic               px_we,
    output logic [COLOR_W-1:0] px_color,
    output logic [ADDR_W-1:0]  px_addr
);

    logic [AW-1:0]      lut_addr;
    logic [COLOR_W-1:0] lut_data;

    pix_layer_sel #(
        .IDX_W     (IDX_W),
        .X_W       (X_W),
        .CLIP_COLS (CLIP_COLS)
    ) u_sel (
        .bg_idx       (bg_idx),
        .bg_pal       (bg_pal),
        .bg_pri       (bg_pri),
        .spr_idx      (spr_idx),
        .pix_x        (pix_x),
        .backdrop_sel (backdrop_sel),
        .left_clip_en (left_clip_en),
        .rd_addr      (lut_addr)
    );

    pix_cram #(
        .COLOR_W (COLOR_W),
        .DEPTH   (DEPTH)
    ) u_cram (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cram_we),
        .wr_addr (cram_waddr),
        .wr_data (cram_wdata),
        .rd_addr (lut_addr),
        .rd_data (lut_data)
    );

    pix_out_stage #(
        .COLOR_W (COLOR_W),
        .X_W     (X_W),
        .LINE_W  (LINE_W)
    ) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .pix_valid (pix_valid),
        .disp_en   (disp_en),
        .lut_data  (lut_data),
        .pix_x     (pix_x),
        .pix_line  (pix_line),
        .px_we     (px_we),
        .px_color  (px_color),
        .px_addr   (px_addr)
    );

endmodule

// File: rtl/pix_mix_chk.sv
module pix_mix_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        pix_valid,
    input logic [7:0]  pix_x,
    input logic [7:0]  pix_line,
    input logic [3:0]  bg_idx,
    input logic        bg_pal,
    input logic        bg_pri,
    input logic [3:0]  spr_idx,
    input logic [3:0]  backdrop_sel,
    input logic        left_clip_en,
    input logic        disp_en,
    input logic [4:0]  sel_addr,
    input logic        px_we,
    input logic [5:0]  px_color,
    input logic [15:0] px_addr
);

    logic clip_zone;
    assign clip_zone = left_clip_en && (pix_x < 8'd8);

    AST_CLIP_BACKDROP: assert property (@(posedge clk) disable iff (!rst_n)
        clip_zone |-> sel_addr == {1'b0, backdrop_sel}); // R5

    AST_BG_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (!clip_zone && bg_idx != 4'd0 && (bg_pri || spr_idx == 4'd0))
        |-> sel_addr == {bg_pal, bg_idx}); // R2

    AST_SPR_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (!clip_zone && spr_idx != 4'd0 && (bg_idx == 4'd0 || !bg_pri))
        |-> sel_addr == {1'b1, spr_idx}); // R3

    AST_BACKDROP_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (!clip_zone && bg_idx == 4'd0 && spr_idx == 4'd0)
        |-> sel_addr == {1'b0, backdrop_sel}); // R4

    AST_BLANK_BLACK: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && !disp_en) |=> px_color == 6'd0); // R6

    AST_ADDR_MAP: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |=> px_addr == {$past(pix_line), $past(pix_x)}); // R7

    AST_WE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |=> px_we); // R8

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_valid |=> (!px_we && $stable(px_color) && $stable(px_addr))); // R8

endmodule

bind pix_mix_top pix_mix_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .pix_valid    (pix_valid),
    .pix_x        (pix_x),
    .pix_line     (pix_line),
    .bg_idx       (bg_idx),
    .bg_pal       (bg_pal),
    .bg_pri       (bg_pri),
    .spr_idx      (spr_idx),
    .backdrop_sel (backdrop_sel),
    .left_clip_en (left_clip_en),
    .disp_en      (disp_en),
    .sel_addr     (lut_addr),
    .px_we        (px_we),
    .px_color     (px_color),
    .px_addr      (px_addr)
);

// File: tb/pix_mix_top_bench.sv
`timescale 1ns/1ps
module pix_mix_top_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pix_valid = 1'b0;
    logic [7:0]  pix_x = '0;
    logic [7:0]  pix_line = '0;
    logic [3:0]  bg_idx = '0;
    logic        bg_pal = 1'b0;
    logic        bg_pri = 1'b0;
    logic [3:0]  spr_idx = '0;
    logic [3:0]  backdrop_sel = '0;
    logic        left_clip_en = 1'b0;
    logic        disp_en = 1'b0;
    logic        cram_we = 1'b0;
    logic [4:0]  cram_waddr = '0;
    logic [5:0]  cram_wdata = '0;
    logic        px_we;
    logic [5:0]  px_color;
    logic [15:0] px_addr;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;
    logic [5:0] mdl [32];
    logic [5:0] last_c = '0;
    logic [15:0] last_a = '0;

    always #2 clk = ~clk;

    pix_mix_top u_pix_mix_top (
        .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_x(pix_x),
        .pix_line(pix_line), .bg_idx(bg_idx), .bg_pal(bg_pal), .bg_pri(bg_pri),
        .spr_idx(spr_idx), .backdrop_sel(backdrop_sel), .left_clip_en(left_clip_en),
        .disp_en(disp_en), .cram_we(cram_we), .cram_waddr(cram_waddr),
        .cram_wdata(cram_wdata), .px_we(px_we), .px_color(px_color), .px_addr(px_addr)
    );

    task automatic check(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic int exp_entry(input logic [3:0] bg, input logic pal, input logic pri,
                                     input logic [3:0] spr, input logic [7:0] x,
                                     input logic [3:0] bd, input logic clip, output string tag);
        if (clip && x < 8) begin tag = "R5"; return int'(bd); end
        if (bg != 0 && (pri || spr == 0)) begin tag = "R2"; return int'(pal) * 16 + int'(bg); end
        if (spr != 0) begin tag = "R3"; return 16 + int'(spr); end
        tag = "R4";
        return int'(bd);
    endfunction

    // Called at a falling edge: drive, predict, let one rising edge pass, compare.
    task automatic run_px(input logic v, input logic [3:0] bg, input logic pal, input logic pri,
                          input logic [3:0] spr, input logic [7:0] x, input logic [7:0] ln,
                          input logic [3:0] bd, input logic clip, input logic disp,
                          input logic we, input logic [4:0] wa, input logic [5:0] wd,
                          input string ctx);
        string tag;
        int e_c;
        int e_a;
        int e_we;
        pix_valid = v; bg_idx = bg; bg_pal = pal; bg_pri = pri; spr_idx = spr;
        pix_x = x; pix_line = ln; backdrop_sel = bd; left_clip_en = clip; disp_en = disp;
        cram_we = we; cram_waddr = wa; cram_wdata = wd;
        if (v) begin
            e_we = 1;
            e_c = int'(mdl[exp_entry(bg, pal, pri, spr, x, bd, clip, tag)]);
            if (!disp) begin e_c = 0; tag = "R6"; end
            e_a = int'(ln) * 256 + int'(x);
        end else begin
            e_we = 0;
            e_c = int'(last_c);
            e_a = int'(last_a);
            tag = "R8";
        end
        if (we) mdl[wa] = wd;   // R9 write lands after the lookup
        @(posedge clk);
        @(negedge clk);
        check({tag, " we ", ctx}, int'(px_we), e_we);
        check({tag, " color ", ctx}, int'(px_color), e_c);
        check({"R7 addr ", ctx}, int'(px_addr), e_a);
        last_c = 6'(e_c);
        last_a = 16'(e_a);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            miscompares++;
            vectors++;
            $display("FAIL watchdog expired, run hung");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        for (int i = 0; i < 32; i++) mdl[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 we in reset", int'(px_we), 0);
        check("R1 color in reset", int'(px_color), 0);
        check("R1 addr in reset", int'(px_addr), 0);
        rst_n = 1'b1;
        // R1: table cleared, so any lookup gives 0
        run_px(1, 4'd5, 1, 1, 4'd0, 8'd40, 8'd3, 4'd0, 0, 1, 0, 5'd0, 6'd0, "R1 cleared table");

        // Load the table with idle pixels: R8 hold, R9 write
        for (int i = 0; i < 32; i++)
            run_px(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1, 5'(i), 6'($urandom), "R9 load");

        run_px(1, 4'd3, 1, 0, 4'd0, 8'd20, 8'd10, 4'd2, 0, 1, 0, 0, 0, "R2 bg alone");
        run_px(1, 4'd3, 0, 1, 4'd9, 8'd21, 8'd10, 4'd2, 0, 1, 0, 0, 0, "R2 bg priority");
        run_px(1, 4'd3, 0, 0, 4'd9, 8'd22, 8'd10, 4'd2, 0, 1, 0, 0, 0, "R3 sprite over bg");
        run_px(1, 4'd0, 1, 1, 4'd7, 8'd23, 8'd10, 4'd2, 0, 1, 0, 0, 0, "R3 bg transparent");
        run_px(1, 4'd0, 1, 1, 4'd0, 8'd24, 8'd10, 4'd11, 0, 1, 0, 0, 0, "R4 both clear");
        run_px(1, 4'd3, 1, 1, 4'd9, 8'd7, 8'd10, 4'd11, 1, 1, 0, 0, 0, "R5 col7 clipped");
        run_px(1, 4'd3, 1, 1, 4'd9, 8'd8, 8'd10, 4'd11, 1, 1, 0, 0, 0, "R5 col8 visible");
        run_px(1, 4'd3, 1, 1, 4'd9, 8'd7, 8'd10, 4'd11, 0, 1, 0, 0, 0, "R5 clip off");
        run_px(1, 4'd3, 1, 1, 4'd9, 8'd2, 8'd10, 4'd11, 1, 0, 0, 0, 0, "R6 off over clip");
        run_px(1, 4'd3, 1, 1, 4'd9, 8'd255, 8'd191, 4'd1, 0, 1, 0, 0, 0, "R7 corner");
        run_px(0, 4'd1, 0, 0, 4'd1, 8'd9, 8'd9, 4'd1, 0, 1, 0, 0, 0, "R8 idle hold");
        // R9 same-cycle write and lookup of entry 19: old value, then new
        run_px(1, 4'd3, 1, 0, 4'd0, 8'd30, 8'd12, 4'd0, 0, 1, 1, 5'd19,
               ~mdl[19], "R9 read old");
        run_px(1, 4'd3, 1, 0, 4'd0, 8'd31, 8'd12, 4'd0, 0, 1, 0, 0, 0, "R9 read new");

        for (int n = 0; n < 2000; n++) begin
            automatic logic [3:0] rb  = ($urandom % 3 == 0) ? 4'd0 : 4'($urandom);
            automatic logic [3:0] rs  = ($urandom % 3 == 0) ? 4'd0 : 4'($urandom);
            automatic logic [7:0] rx  = ($urandom % 4 == 0) ? 8'($urandom % 12) : 8'($urandom);
            run_px(($urandom % 5) != 0, rb, 1'($urandom), 1'($urandom), rs, rx,
                   8'($urandom), 4'($urandom), 1'($urandom), ($urandom % 8) != 0,
                   ($urandom % 5) == 0, 5'($urandom), 6'($urandom), "random");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule